// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Register Port

This block sits between a processor-side register bus and the byte streams of an SPI shift engine. Software writes outgoing bytes into a 16-entry transmit FIFO and collects incoming bytes from a 16-entry receive FIFO. The engine drains the transmit FIFO and fills the receive FIFO through ready/valid handshakes. A control bit switches the data ports between two modes. In byte mode one byte moves per access. In word mode four bytes move per access on the word port, packed little-endian.

A status word combines two kinds of bit. The live FIFO level flags are the ones software polls before every data access. The sticky event bits (transmit done, receive done, receive data arrived) are cleared by writing 1. An enable mask gates the low six status bits into a single interrupt line.

Receive arrival is tracked by a two-state machine, `rx_watch_e`:
- `RXW_EMPTY`: the receive FIFO held nothing on the previous cycle.
- `RXW_HELD`: it held at least one byte.

The machine has two transitions:
- `RXW_EMPTY` to `RXW_HELD` when the FIFO becomes non-empty. This transition raises the arrival event.
- `RXW_HELD` to `RXW_EMPTY` when the FIFO drains to zero.

The register select is the enum `reg_sel_e`. Its values are: 0 control, 1 interrupt enable, 2 status, 3 byte data, 4 word data.

Top module: `spi_fifo_port`

## Requirements
- R1: After reset both FIFOs are empty, tx_valid is 0 and rx_ready is 1. The status word (address 2) then reads bit3 = 1, bit4 = 1, bit7 = eng_idle and every other bit 0. The interrupt line is low because the enable register resets to 0.
- R2: In byte mode, a write to address 3 queues bus_wdata[7:0] if fewer than 16 bytes are held; a write to a full FIFO is dropped. Queued bytes are presented on tx_byte with tx_valid high, in write order, and one byte leaves per cycle in which tx_ready is high.
- R3: The engine's byte is accepted in any cycle with rx_valid high and fewer than 16 bytes held (rx_ready high). A read of address 3 returns {24'b0, oldest byte} and removes it. A read of address 3 while the FIFO is empty returns 0 and removes nothing.
- R4: With control bit0 set (word mode), a write to address 4 queues four bytes: bits 7:0 go out first, then 15:8, 23:16 and 31:24. The write is dropped when fewer than four slots are free.
- R5: In word mode, a read of address 4 returns the four oldest received bytes, with the oldest in bits 7:0, and removes them. When fewer than four bytes are held, the read returns 0 and removes nothing.
- R6: While control bit0 is clear, writes to address 4 are ignored and reads of address 4 return 0 without removing data.
- R7: Status bit5 (transmit full) is set in byte mode when 16 bytes are held, and in word mode when fewer than 4 slots are free. Bit3 (transmit space) is the inverse of bit5. Bit4 (receive empty) is set in byte mode when 0 bytes are held, and in word mode when fewer than 4 are held. All three follow the current fill level on the cycle after any push or pop.
- R8: Status bit0 is set by a one-cycle eng_tx_done pulse and bit1 by a one-cycle eng_rx_done pulse. A bit stays set until a status write with 1 in that position. Writing 0 leaves it set. A pulse in the same cycle as a clear leaves the bit set.
- R9: Status bit2 is set one cycle after the receive FIFO goes from empty to non-empty. It is cleared by writing 1 to bit2, and it is not set again while the FIFO stays non-empty.
- R10: irq is the OR over bits 0 to 5 of (status AND the enable register at address 1).
- R11: Status bit8 reads the word-mode control bit. Bit6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data ports) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_byte | output | 8 | Oldest transmit byte to engine |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_ready | input | 1 | Engine takes tx_byte this cycle |
| rx_byte | input | 8 | Received byte from engine |
| rx_valid | input | 1 | Engine offers rx_byte |
| rx_ready | output | 1 | Receive FIFO has room |
| eng_tx_done | input | 1 | One-cycle transmit-complete pulse |
| eng_rx_done | input | 1 | One-cycle receive-complete pulse |
| eng_idle | input | 1 | Engine idle level, shown in status bit7 |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational: the bench samples bus_rdata 1 ns after the negative edge at which it raises the strobe, and the pop takes effect at the following rising edge. A push or pop changes tx_valid, rx_ready and the level flags right after the edge that performs it. The done bits appear after the edge that samples the pulse, and the arrival bit appears one edge later still. Every bench operation starts with a full idle cycle, so each sampled result has reached its settled value. The reference queues and sticky bits are therefore updated per operation, not per cycle, and irq is compared after every operation.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_IEN  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_BYTE = 3'd3,
        SEL_WORD = 3'd4
    } reg_sel_e;

    typedef enum logic {
        RXW_EMPTY = 1'b0,
        RXW_HELD  = 1'b1
    } rx_watch_e;

    localparam int EV_W    = 6;
    localparam int STICKY_W = 3;
    localparam int STAT_W  = 9;

endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
    parameter  int DEPTH = 16,
    parameter  int LANES = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        push_n,
    input  logic [LANES*8-1:0]   push_data,
    input  logic [NW-1:0]        pop_n,
    output logic [LANES*8-1:0]   peek_data,
    output logic [CW-1:0]        count
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (NW'(i) < push_n) begin
                mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            peek_data[i*8 +: 8] = mem[rd_ptr + AW'(i)];
        end
    end

    // R2 / R4: callers never push past capacity
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) + int'(push_n) - int'(pop_n)) <= DEPTH);

    // R3 / R5: callers never pop more than is held
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(count));

endmodule

// File: rtl/sfp_status.sv
module sfp_status
    import spi_fifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_done_i,
    input  logic                rx_done_i,
    input  logic                rx_nonempty_i,
    input  logic [STICKY_W-1:0] clr_i,
    input  logic                tx_space_i,
    input  logic                rx_empty_i,
    input  logic                tx_full_i,
    input  logic [EV_W-1:0]     ien_i,
    output logic [EV_W-1:0]     status_o,
    output logic                irq_o
);

    rx_watch_e           state_q;
    rx_watch_e           state_d;
    logic                arrival;
    logic [STICKY_W-1:0] sticky_q;
    logic [STICKY_W-1:0] set_v;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXW_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        arrival = 1'b0;
        unique case (state_q)
            RXW_EMPTY: begin
                if (rx_nonempty_i) begin
                    state_d = RXW_HELD;
                    arrival = 1'b1;
                end
            end
            RXW_HELD: begin
                if (!rx_nonempty_i) begin
                    state_d = RXW_EMPTY;
                end
            end
            default: state_d = RXW_EMPTY;
        endcase
    end

    assign set_v = {arrival, rx_done_i, tx_done_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= set_v | (sticky_q & ~clr_i);
        end
    end

    assign status_o = {tx_full_i, rx_empty_i, tx_space_i, sticky_q};
    assign irq_o    = |(status_o & ien_i);

    // R8: a set done bit survives any cycle without a clear on its position
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q[0] && !clr_i[0]) |=> sticky_q[0]);

    // R8: a done pulse always leaves its bit set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> sticky_q[1]);

    // R9: first byte into an empty receive FIFO flags arrival on the next cycle
    a_r9_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXW_EMPTY && rx_nonempty_i) |=> sticky_q[2]);

endmodule

// File: rtl/spi_fifo_port.sv
module spi_fifo_port
    import spi_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int LANES = 4,
    localparam int DW    = LANES * 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [7:0]    tx_byte,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [7:0]    rx_byte,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic          eng_tx_done,
    input  logic          eng_rx_done,
    input  logic          eng_idle,
    output logic          irq
);

    logic                word_mode;
    logic [EV_W-1:0]     ien;
    logic [EV_W-1:0]     ev_status;
    logic [STAT_W-1:0]   status_word;
    logic [STICKY_W-1:0] clr_mask;

    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_free;
    logic [DW-1:0] tx_peek;
    logic [DW-1:0] rx_peek;
    logic [DW-1:0] tx_lanes;
    logic [NW-1:0] tx_push_n;
    logic [NW-1:0] tx_pop_n;
    logic [NW-1:0] rx_push_n;
    logic [NW-1:0] rx_pop_n;

    logic hit_ctrl, hit_ien, hit_stat, hit_byte, hit_word;
    logic byte_wr_ok, word_wr_ok, byte_rd_ok, word_rd_ok;
    logic tx_full_f, rx_empty_f;

    always_comb begin
        hit_ctrl = (bus_addr == SEL_CTRL);
        hit_ien  = (bus_addr == SEL_IEN);
        hit_stat = (bus_addr == SEL_STAT);
        hit_byte = (bus_addr == SEL_BYTE);
        hit_word = (bus_addr == SEL_WORD);
    end

    // level flags, thresholds picked by the mode bit
    always_comb begin
        tx_free    = CW'(DEPTH) - tx_cnt;
        tx_full_f  = word_mode ? (tx_free < CW'(LANES)) : (tx_free == '0);
        rx_empty_f = word_mode ? (rx_cnt < CW'(LANES)) : (rx_cnt == '0);
    end

    // transmit side
    always_comb begin
        byte_wr_ok = bus_wr && hit_byte && (tx_free != '0);
        word_wr_ok = bus_wr && hit_word && word_mode && (tx_free >= CW'(LANES));
        tx_push_n  = word_wr_ok ? NW'(LANES) : (byte_wr_ok ? NW'(1) : '0);
        tx_lanes   = word_wr_ok ? bus_wdata : {{(DW-8){1'b0}}, bus_wdata[7:0]};
        tx_valid   = (tx_cnt != '0);
        tx_byte    = tx_peek[7:0];
        tx_pop_n   = (tx_valid && tx_ready) ? NW'(1) : '0;
    end

    // receive side
    always_comb begin
        rx_ready   = (rx_cnt != CW'(DEPTH));
        rx_push_n  = (rx_valid && rx_ready) ? NW'(1) : '0;
        byte_rd_ok = bus_rd && hit_byte && (rx_cnt != '0);
        word_rd_ok = bus_rd && hit_word && word_mode && (rx_cnt >= CW'(LANES));
        rx_pop_n   = word_rd_ok ? NW'(LANES) : (byte_rd_ok ? NW'(1) : '0);
    end

    sfp_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_lanes),
        .pop_n     (tx_pop_n),
        .peek_data (tx_peek),
        .count     (tx_cnt)
    );

    sfp_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data ({{(DW-8){1'b0}}, rx_byte}),
        .pop_n     (rx_pop_n),
        .peek_data (rx_peek),
        .count     (rx_cnt)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_mode <= 1'b0;
            ien       <= '0;
        end else if (bus_wr) begin
            if (hit_ctrl) word_mode <= bus_wdata[0];
            if (hit_ien)  ien       <= bus_wdata[EV_W-1:0];
        end
    end

    assign clr_mask = (bus_wr && hit_stat) ? bus_wdata[STICKY_W-1:0] : '0;

    sfp_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_done_i     (eng_tx_done),
        .rx_done_i     (eng_rx_done),
        .rx_nonempty_i (rx_cnt != '0),
        .clr_i         (clr_mask),
        .tx_space_i    (!tx_full_f),
        .rx_empty_i    (rx_empty_f),
        .tx_full_i     (tx_full_f),
        .ien_i         (ien),
        .status_o      (ev_status),
        .irq_o         (irq)
    );

    assign status_word = {word_mode, eng_idle, 1'b0, ev_status};

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_ctrl) bus_rdata = DW'(word_mode);
            if (hit_ien)  bus_rdata = DW'(ien);
            if (hit_stat) bus_rdata = DW'(status_word);
            if (byte_rd_ok) bus_rdata = {{(DW-8){1'b0}}, rx_peek[7:0]};
            if (word_rd_ok) bus_rdata = rx_peek;
        end
    end

    // R6: word port is inert in byte mode
    a_r6_word_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_word && !word_mode) |-> (bus_rdata == '0));

    // R3: an empty receive FIFO reads as zero on the byte port
    a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_byte && rx_cnt == '0) |-> (bus_rdata == '0));

    // R2: the engine never sees valid data from an empty transmit FIFO
    a_r2_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0 && !bus_wr) |=> !tx_valid);

endmodule

// File: tb/spi_fifo_port_tb.sv
`timescale 1ns/1ps
module spi_fifo_port_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        eng_tx_done = 1'b0;
    logic        eng_rx_done = 1'b0;
    logic        eng_idle = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit m_mode = 0;
    bit m_txd = 0, m_rxd = 0, m_rxa = 0;
    logic [5:0] m_ien = '0;

    always #4 clk = ~clk;

    spi_fifo_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done),
        .eng_idle(eng_idle), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        int tfree = DEPTH - txq.size();
        bit tfull = m_mode ? (tfree < 4) : (tfree == 0);
        s[0] = m_txd;
        s[1] = m_rxd;
        s[2] = m_rxa;
        s[3] = !tfull;
        s[4] = m_mode ? (rxq.size() < 4) : (rxq.size() == 0);
        s[5] = tfull;
        s[7] = eng_idle;
        s[8] = m_mode;
        return s;
    endfunction

    function automatic logic exp_irq();
        logic [31:0] s = exp_status();
        return |(s[5:0] & m_ien);
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        bus_write(3'd0, {31'b0, m});
        m_mode = m;
    endtask

    task automatic set_ien(input logic [5:0] e);
        bus_write(3'd1, {26'b0, e});
        m_ien = e;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        bus_write(3'd3, {24'hABCDEF, b});
        if (txq.size() < DEPTH) txq.push_back(b);
    endtask

    task automatic wr_word(input logic [31:0] w);
        bus_write(3'd4, w);
        if (m_mode && (DEPTH - txq.size()) >= 4)
            for (int i = 0; i < 4; i++) txq.push_back(w[i*8 +: 8]);
    endtask

    task automatic rd_byte();
        logic [31:0] d, e;
        e = (rxq.size() != 0) ? {24'b0, rxq[0]} : 32'b0;
        bus_read(3'd3, d);
        chk("R3 byte read", d, e);
        if (rxq.size() != 0) void'(rxq.pop_front());
    endtask

    task automatic rd_word(input string req);
        logic [31:0] d, e;
        e = '0;
        if (m_mode && rxq.size() >= 4)
            for (int i = 0; i < 4; i++) e[i*8 +: 8] = rxq[i];
        bus_read(3'd4, d);
        chk(req, d, e);
        if (m_mode && rxq.size() >= 4)
            for (int i = 0; i < 4; i++) void'(rxq.pop_front());
    endtask

    task automatic eng_push(input logic [7:0] b);
        logic acc;
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        #1 acc = rx_ready;
        chk("R3 rx_ready", {31'b0, acc}, {31'b0, rxq.size() < DEPTH});
        @(negedge clk);
        rx_valid = 1'b0;
        if (rxq.size() < DEPTH) begin
            if (rxq.size() == 0) m_rxa = 1;
            rxq.push_back(b);
        end
    endtask

    task automatic eng_take();
        logic v;
        logic [7:0] b;
        @(negedge clk);
        tx_ready = 1'b1;
        #1 v = tx_valid; b = tx_byte;
        chk("R2 tx_valid", {31'b0, v}, {31'b0, txq.size() != 0});
        if (txq.size() != 0) begin
            chk("R2 tx order", {24'b0, b}, {24'b0, txq[0]});
            void'(txq.pop_front());
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic pulse(input bit t, input bit r);
        @(negedge clk);
        eng_tx_done = t; eng_rx_done = r;
        @(negedge clk);
        eng_tx_done = 1'b0; eng_rx_done = 1'b0;
        if (t) m_txd = 1;
        if (r) m_rxd = 1;
    endtask

    task automatic clear_status(input logic [2:0] m);
        bus_write(3'd2, {29'h1FFFFFF8 & 29'h0, m});
        if (m[0]) m_txd = 0;
        if (m[1]) m_rxd = 0;
        if (m[2]) m_rxa = 0;
    endtask

    task automatic check_status(input string req);
        logic [31:0] d;
        bus_read(3'd2, d);
        chk(req, d, exp_status());
    endtask

    task automatic check_irq();
        @(negedge clk);
        #1 chk("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        check_status("R1 status");
        rd_byte();                      // R3 empty read gives 0

        // R4 word write order
        set_mode(1);
        check_status("R11 mode bit");
        wr_word(32'h44332211);
        repeat (4) eng_take();
        eng_take();                     // R2 empty again

        // R6 word port inert in byte mode
        set_mode(0);
        wr_word(32'hDEADBEEF);
        eng_take();
        eng_push(8'h5A);
        rd_word("R6 word read in byte mode");
        rd_byte();

        // R2 / R7 fill transmit FIFO, overflow dropped
        for (int i = 0; i < 17; i++) wr_byte(8'(i + 8'h30));
        check_status("R7 byte full");
        set_mode(1);
        eng_take(); eng_take(); eng_take();
        check_status("R7 word full with 3 free");
        wr_word(32'h01020304);          // R4 refused
        eng_take();
        wr_word(32'hA1B2C3D4);
        check_status("R7 word full again");
        while (txq.size() != 0) eng_take();

        // R5 word read refused then allowed
        clear_status(3'b100);
        eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
        rd_word("R5 word read short");
        check_status("R9 arrival set");
        clear_status(3'b100);
        eng_push(8'h44);
        check_status("R9 no re-arm while held");
        rd_word("R5 word read");
        check_status("R7 rx empty");

        // R3 receive overflow
        set_mode(0);
        for (int i = 0; i < 17; i++) eng_push(8'(i));
        check_status("R3 rx full");
        while (rxq.size() != 0) rd_byte();

        // R8 sticky done bits, W0 no effect, set wins over clear
        pulse(1, 1);
        clear_status(3'b000);
        check_status("R8 write 0 keeps");
        clear_status(3'b001);
        check_status("R8 clear tx done");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h2; eng_rx_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_rx_done = 1'b0;
        check_status("R8 set wins");

        // R10 irq masking
        set_ien(6'b000010);
        check_irq();
        clear_status(3'b111);
        check_irq();
        set_ien(6'b001000);
        check_irq();

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 11);
            case (op)
                0: wr_byte(8'($urandom));
                1: wr_word($urandom);
                2: rd_byte();
                3: rd_word("R5 random word read");
                4, 5: eng_push(8'($urandom));
                6: eng_take();
                7: pulse(1'($urandom), 1'($urandom));
                8: clear_status(3'($urandom));
                9: set_mode(1'($urandom));
                10: set_ien(6'($urandom));
                default: begin
                    @(negedge clk);
                    eng_idle = 1'($urandom);
                end
            endcase
            check_irq();
            if ((n % 5) == 0) check_status("R7 random status");
        end

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule